// File: doc/BRIEF.md
# Programmable AND-OR Array with Output Feedback

This block is a combinational sum-of-products engine whose AND plane and OR plane are both set at run time. Each product term ANDs any chosen set of literals. A literal is a primary input or a sum output, in true or complemented form. Each sum output ORs any chosen subset of the product terms and can then be inverted. Any product term may feed any number of outputs, and no output is limited in how many terms it collects.

The configuration is held in flip-flops and loaded one row at a time through a parallel write port. A write names a plane, a row index and a data word. When configuration is stable, the path from `in_i` to `out_o` is purely combinational.

Feedback is evaluated as an unrolled cascade of `NUM_OUT` copies of the array. Stage 0 sees every fed-back output as 0, and each later stage sees the outputs of the stage before it. The last stage drives the pins. For any configuration whose feedback chain is no deeper than `NUM_OUT` outputs, the pins show the settled value.

Top module: `pla_feedback_array`

## Requirements
- R1: After reset both planes hold all zeros, so `out_o` is 0 for every value of `in_i` until the first configuration write.
- R2: An AND-plane row word uses bit 2k for the true form of source k and bit 2k+1 for its complement. Sources 0..NUM_IN-1 are `in_i` bits, and source NUM_IN+j is `out_o[j]` fed back. The term is the AND of every selected literal.
- R3: A product term with no literal selected evaluates to 0. A term that selects both forms of one source also evaluates to 0.
- R4: In an OR-plane row word, bit t selects product term t for t in 0..NUM_TERM-1, and any subset may be chosen. An output with no term selected is 0 before inversion.
- R5: One product term selected in several OR rows contributes to each of those outputs at the same time.
- R6: Bit NUM_TERM of an OR-plane row word inverts that output after the OR.
- R7: Fed-back outputs act as AND-plane literals. A function built from an output that itself depends only on primary inputs gives the settled result at the pins.
- R8: A write (`cfg_we`=1; `cfg_plane`=0 for AND, 1 for OR) takes effect on the rising clock edge where it is sampled. `out_o` follows `in_i` combinationally.
- R9: A write whose row index is not below the plane's row count (NUM_TERM for AND, NUM_OUT for OR) changes nothing.
- R10: `cfg_data` bits above a plane's row word width (2*(NUM_IN+NUM_OUT) for AND, NUM_TERM+1 for OR) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset, clears both planes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_plane | input | 1 | Plane select: 0 AND plane, 1 OR plane |
| cfg_row | input | ROW_W (2) | Row index within the selected plane |
| cfg_data | input | CFG_W (10) | Row word to store |
| in_i | input | NUM_IN (3) | Primary inputs |
| out_o | output | NUM_OUT (2) | Sum outputs |

## Verification
On every cycle, the assertions check three things. Outputs stay 0 from reset until the first write. Outputs hold still when neither inputs nor configuration have changed. A write to a row outside the selected plane leaves the outputs unchanged. They also check that the outputs are never unknown.

The logic functions themselves can only be shown by the bench scenarios. These sweep all input combinations under several configurations: terms shared between two outputs, complemented literals with inversion, empty and contradictory terms, and a three-input parity built through feedback. Each result is compared with a model computed from the row-word encodings.

// File: rtl/pla_pkg.sv
// Shared definitions for the programmable AND-OR array.
// Assumes: plane select is a single bit at the block's edge.
package pla_pkg;

    typedef enum logic {
        PLANE_AND = 1'b0,
        PLANE_OR  = 1'b1
    } plane_e;

    // Number of literal bits in one AND-plane row word.
    function automatic int lit_width(input int n_in, input int n_out);
        return 2 * (n_in + n_out);
    endfunction

    // Larger of two sizes, used for shared word and index widths.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
// Configuration registers for both planes, one register per row.
// Assumes: the write decode is synchronous; rows outside a plane never match,
// so out-of-range writes are dropped.
module pla_cfg_store
    import pla_pkg::*;
#(
    parameter int NUM_IN   = 3,
    parameter int NUM_TERM = 4,
    parameter int NUM_OUT  = 2,
    parameter int ROW_W    = 2,
    parameter int CFG_W    = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  plane_e                       wr_plane,
    input  logic [ROW_W-1:0]             wr_row,
    input  logic [CFG_W-1:0]             wr_data,
    output logic [NUM_TERM*lit_width(NUM_IN, NUM_OUT)-1:0] and_rows,
    output logic [NUM_OUT*NUM_TERM-1:0]  or_rows,
    output logic [NUM_OUT-1:0]           inv_bits
);
    localparam int LIT_W = lit_width(NUM_IN, NUM_OUT);

    generate
        for (genvar t = 0; t < NUM_TERM; t++) begin : g_and_row
            logic [LIT_W-1:0] row_q;
            // Load one AND-plane row when its index is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    row_q <= '0;
                else if (wr_en && wr_plane == PLANE_AND && wr_row == ROW_W'(t))
                    row_q <= wr_data[LIT_W-1:0];
            end
            assign and_rows[t*LIT_W +: LIT_W] = row_q;
        end

        for (genvar o = 0; o < NUM_OUT; o++) begin : g_or_row
            logic [NUM_TERM-1:0] sel_q;
            logic                inv_q;
            // Load one OR-plane row (term selection plus inversion bit).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel_q <= '0;
                    inv_q <= 1'b0;
                end else if (wr_en && wr_plane == PLANE_OR && wr_row == ROW_W'(o)) begin
                    sel_q <= wr_data[NUM_TERM-1:0];
                    inv_q <= wr_data[NUM_TERM];
                end
            end
            assign or_rows[o*NUM_TERM +: NUM_TERM] = sel_q;
            assign inv_bits[o] = inv_q;
        end
    endgenerate

endmodule

// File: rtl/pla_and_plane.sv
// AND plane: each product term is the AND of its selected literals.
// Assumes: a term with no literal selected must read 0, not 1.
module pla_and_plane #(
    parameter int LIT_W    = 10,
    parameter int NUM_TERM = 4
) (
    input  logic [LIT_W-1:0]          lits,
    input  logic [NUM_TERM*LIT_W-1:0] masks,
    output logic [NUM_TERM-1:0]       terms
);
    generate
        for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
            logic [LIT_W-1:0] m;
            assign m = masks[t*LIT_W +: LIT_W];
            // Term is true only when at least one literal is selected and all selected are 1.
            always_comb begin
                terms[t] = (|m) && (&(~m | lits));
            end
        end
    endgenerate

endmodule

// File: rtl/pla_or_plane.sv
// OR plane: each output ORs its selected terms, then optionally inverts.
// Assumes: terms may be shared by any number of outputs.
module pla_or_plane #(
    parameter int NUM_TERM = 4,
    parameter int NUM_OUT  = 2
) (
    input  logic [NUM_TERM-1:0]         terms,
    input  logic [NUM_OUT*NUM_TERM-1:0] sel,
    input  logic [NUM_OUT-1:0]          inv,
    output logic [NUM_OUT-1:0]          sums
);
    generate
        for (genvar o = 0; o < NUM_OUT; o++) begin : g_sum
            // Collect the chosen terms for this output and apply polarity.
            always_comb begin
                sums[o] = (|(terms & sel[o*NUM_TERM +: NUM_TERM])) ^ inv[o];
            end
        end
    endgenerate

endmodule

// File: rtl/pla_stage.sv
// One evaluation stage: forms the literal vector from primary inputs and
// the previous stage's outputs, then runs both planes.
// Assumes: feedback values come from an earlier stage, so no loop is formed.
module pla_stage
    import pla_pkg::*;
#(
    parameter int NUM_IN   = 3,
    parameter int NUM_TERM = 4,
    parameter int NUM_OUT  = 2
) (
    input  logic [NUM_IN-1:0]  prim,
    input  logic [NUM_OUT-1:0] fb,
    input  logic [NUM_TERM*lit_width(NUM_IN, NUM_OUT)-1:0] and_rows,
    input  logic [NUM_OUT*NUM_TERM-1:0] or_rows,
    input  logic [NUM_OUT-1:0] inv_bits,
    output logic [NUM_OUT-1:0] sums
);
    localparam int NUM_SRC = NUM_IN + NUM_OUT;
    localparam int LIT_W   = lit_width(NUM_IN, NUM_OUT);

    logic [NUM_SRC-1:0]  src;
    logic [LIT_W-1:0]    lits;
    logic [NUM_TERM-1:0] terms;

    assign src = {fb, prim};

    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_lit
            // Provide true and complemented copies of each source.
            always_comb begin
                lits[2*k]   = src[k];
                lits[2*k+1] = ~src[k];
            end
        end
    endgenerate

    pla_and_plane #(
        .LIT_W    (LIT_W),
        .NUM_TERM (NUM_TERM)
    ) u_and (
        .lits  (lits),
        .masks (and_rows),
        .terms (terms)
    );

    pla_or_plane #(
        .NUM_TERM (NUM_TERM),
        .NUM_OUT  (NUM_OUT)
    ) u_or (
        .terms (terms),
        .sel   (or_rows),
        .inv   (inv_bits),
        .sums  (sums)
    );

endmodule

// File: rtl/pla_feedback_array.sv
// Top: programmable AND-OR array with output feedback.
// Assumes: feedback chains are at most NUM_OUT deep; deeper or cyclic
// configurations give the value of the unrolled cascade.
module pla_feedback_array
    import pla_pkg::*;
#(
    parameter int NUM_IN   = 3,
    parameter int NUM_TERM = 4,
    parameter int NUM_OUT  = 2,
    parameter int ROW_W    = $clog2(max2(max2(NUM_TERM, NUM_OUT), 2)),
    parameter int CFG_W    = max2(lit_width(NUM_IN, NUM_OUT), NUM_TERM + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_plane,
    input  logic [ROW_W-1:0]   cfg_row,
    input  logic [CFG_W-1:0]   cfg_data,
    input  logic [NUM_IN-1:0]  in_i,
    output logic [NUM_OUT-1:0] out_o
);
    localparam int LIT_W     = lit_width(NUM_IN, NUM_OUT);
    localparam int NUM_STAGE = NUM_OUT;

    logic [NUM_TERM*LIT_W-1:0]   and_rows;
    logic [NUM_OUT*NUM_TERM-1:0] or_rows;
    logic [NUM_OUT-1:0]          inv_bits;
    logic [NUM_OUT-1:0]          stage_out [NUM_STAGE];

    pla_cfg_store #(
        .NUM_IN   (NUM_IN),
        .NUM_TERM (NUM_TERM),
        .NUM_OUT  (NUM_OUT),
        .ROW_W    (ROW_W),
        .CFG_W    (CFG_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_plane (plane_e'(cfg_plane)),
        .wr_row   (cfg_row),
        .wr_data  (cfg_data),
        .and_rows (and_rows),
        .or_rows  (or_rows),
        .inv_bits (inv_bits)
    );

    generate
        for (genvar s = 0; s < NUM_STAGE; s++) begin : g_stage
            logic [NUM_OUT-1:0] fb;
            if (s == 0) begin : g_first
                assign fb = '0;
            end else begin : g_next
                assign fb = stage_out[s-1];
            end

            pla_stage #(
                .NUM_IN   (NUM_IN),
                .NUM_TERM (NUM_TERM),
                .NUM_OUT  (NUM_OUT)
            ) u_stage (
                .prim     (in_i),
                .fb       (fb),
                .and_rows (and_rows),
                .or_rows  (or_rows),
                .inv_bits (inv_bits),
                .sums     (stage_out[s])
            );
        end
    endgenerate

    assign out_o = stage_out[NUM_STAGE-1];

endmodule

// File: rtl/pla_feedback_array_chk.sv
// Checker for the programmable AND-OR array, attached by bind.
// Assumes: synchronous active-low reset as in the top module.
module pla_feedback_array_chk #(
    parameter int NUM_IN   = 3,
    parameter int NUM_TERM = 4,
    parameter int NUM_OUT  = 2,
    parameter int ROW_W    = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic               cfg_plane,
    input logic [ROW_W-1:0]   cfg_row,
    input logic [NUM_IN-1:0]  in_i,
    input logic [NUM_OUT-1:0] out_o
);
    logic wr_seen;
    logic oob_wr;

    // Remember whether any write has occurred since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_seen <= 1'b0;
        else if (cfg_we)
            wr_seen <= 1'b1;
    end

    // Flag a write whose row lies outside the selected plane.
    always_comb begin
        oob_wr = cfg_we && (cfg_plane ? (int'(cfg_row) >= NUM_OUT)
                                      : (int'(cfg_row) >= NUM_TERM));
    end

    a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_seen |-> (out_o == '0));

    a_r8_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(in_i) && !$past(cfg_we)) |-> $stable(out_o));

    a_r9_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        oob_wr |=> ($stable(out_o) || !$stable(in_i)));

    a_r2_out_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(out_o));

endmodule

bind pla_feedback_array pla_feedback_array_chk #(
    .NUM_IN   (NUM_IN),
    .NUM_TERM (NUM_TERM),
    .NUM_OUT  (NUM_OUT),
    .ROW_W    (ROW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_plane (cfg_plane),
    .cfg_row   (cfg_row),
    .in_i      (in_i),
    .out_o     (out_o)
);

// File: tb/pla_feedback_array_tb.sv
module pla_feedback_array_tb;
    localparam int NUM_IN = 3, NUM_TERM = 4, NUM_OUT = 2, ROW_W = 2;
    localparam int LIT_W = 2 * (NUM_IN + NUM_OUT);
    localparam int CFG_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic cfg_plane = 1'b0;
    logic [ROW_W-1:0] cfg_row = '0;
    logic [CFG_W-1:0] cfg_data = '0;
    logic [NUM_IN-1:0] in_i = '0;
    logic [NUM_OUT-1:0] out_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [LIT_W-1:0]    m_and [NUM_TERM];
    logic [NUM_TERM:0]   m_or  [NUM_OUT];

    always #10 clk = ~clk;

    pla_feedback_array u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
        .cfg_row(cfg_row), .cfg_data(cfg_data), .in_i(in_i), .out_o(out_o)
    );

    // Reference: row-word encodings from the requirements, feedback settled by iteration.
    function automatic logic [NUM_OUT-1:0] ref_eval(input logic [NUM_IN-1:0] x);
        logic [NUM_OUT-1:0] fb = '0;
        logic [NUM_OUT-1:0] nx;
        for (int it = 0; it < NUM_OUT; it++) begin
            logic [NUM_IN+NUM_OUT-1:0] src;
            logic [NUM_TERM-1:0] tm;
            src = {fb, x};
            for (int t = 0; t < NUM_TERM; t++) begin
                logic v;
                v = (m_and[t] != '0);
                for (int k = 0; k < NUM_IN + NUM_OUT; k++) begin
                    if (m_and[t][2*k] && !src[k]) v = 1'b0;
                    if (m_and[t][2*k+1] && src[k]) v = 1'b0;
                end
                tm[t] = v;
            end
            for (int o = 0; o < NUM_OUT; o++)
                nx[o] = (|(tm & m_or[o][NUM_TERM-1:0])) ^ m_or[o][NUM_TERM];
            fb = nx;
        end
        return fb;
    endfunction

    task automatic check(input string req, input logic [NUM_OUT-1:0] exp);
        n_chk++;
        if (out_o !== exp) begin
            n_fail++;
            $display("FAIL %s in=%b actual=%b expected=%b", req, in_i, out_o, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int v = 0; v < (1 << NUM_IN); v++) begin
            in_i = NUM_IN'(v);
            #1;
            check(req, ref_eval(in_i));
        end
    endtask

    task automatic cfg_write(input logic plane, input int row, input logic [CFG_W-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_plane = plane; cfg_row = ROW_W'(row); cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!plane && row < NUM_TERM) m_and[row] = data[LIT_W-1:0];
        if (plane && row < NUM_OUT)   m_or[row]  = data[NUM_TERM:0];
    endtask

    // R1: reset clears both planes, every input gives 0.
    task automatic t_reset;
        for (int v = 0; v < (1 << NUM_IN); v++) begin
            in_i = NUM_IN'(v);
            #1;
            check("R1 reset", '0);
        end
    endtask

    // R2 R4 R5: ab+ac and ac+bc share term ac (a=in0, b=in1, c=in2).
    task automatic t_shared;
        cfg_write(1'b0, 0, 10'h005);
        cfg_write(1'b0, 1, 10'h011);
        cfg_write(1'b0, 2, 10'h014);
        cfg_write(1'b0, 3, 10'h000);
        cfg_write(1'b1, 0, 10'h003);
        cfg_write(1'b1, 1, 10'h006);
        sweep("R5 shared term");
    endtask

    // R2 R6 R10: complemented literals, inverted output, high data bits ignored.
    task automatic t_complement;
        cfg_write(1'b0, 0, 10'h026);
        cfg_write(1'b0, 1, 10'h011);
        cfg_write(1'b0, 2, 10'h002);
        cfg_write(1'b1, 0, 10'h3E3);
        cfg_write(1'b1, 1, 10'h014);
        sweep("R6 R10 complement and invert");
    endtask

    // R3 R4: empty term, contradictory term, empty OR row.
    task automatic t_empty;
        cfg_write(1'b0, 0, 10'h000);
        cfg_write(1'b0, 1, 10'h003);
        cfg_write(1'b1, 0, 10'h003);
        cfg_write(1'b1, 1, 10'h000);
        sweep("R3 empty or contradictory term");
        cfg_write(1'b1, 1, 10'h010);
        in_i = 3'b101; #1;
        check("R4 empty OR row inverted", 2'b10);
    endtask

    // R7: out0 = a^b, out1 = out0^c via feedback literals (bits 6,7).
    task automatic t_feedback;
        cfg_write(1'b0, 0, 10'h006);
        cfg_write(1'b0, 1, 10'h009);
        cfg_write(1'b0, 2, 10'h060);
        cfg_write(1'b0, 3, 10'h090);
        cfg_write(1'b1, 0, 10'h003);
        cfg_write(1'b1, 1, 10'h00C);
        for (int v = 0; v < 8; v++) begin
            in_i = 3'(v); #1;
            check("R7 feedback parity", {^in_i, in_i[0] ^ in_i[1]});
        end
    endtask

    // R9: OR rows 2 and 3 do not exist; writes there change nothing.
    task automatic t_oob;
        cfg_write(1'b1, 2, 10'h3FF);
        cfg_write(1'b1, 3, 10'h3FF);
        sweep("R9 out-of-range write");
    endtask

    // R8: new row word visible only after the sampling edge.
    task automatic t_timing;
        in_i = 3'b111;
        @(negedge clk);
        cfg_we = 1'b1; cfg_plane = 1'b1; cfg_row = 2'd0; cfg_data = 10'h010;
        #1;
        check("R8 before edge", ref_eval(in_i));
        @(negedge clk);
        cfg_we = 1'b0;
        m_or[0] = 5'h10;
        #1;
        check("R8 after edge", ref_eval(in_i));
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int t = 0; t < NUM_TERM; t++) m_and[t] = '0;
        for (int o = 0; o < NUM_OUT; o++) m_or[o] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shared();
        t_complement();
        t_empty();
        t_feedback();
        t_oob();
        t_timing();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule